// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Divider

This block turns the system clock into the serial clock of an SPI controller. The total division is the product of two stages. The first stage divides by a small odd or prime value taken from a set of four. The second stage divides by a value from a sixteen-entry table: linear steps at the low end, then powers of two. A double-rate bit halves the product, so the serial clock runs twice as fast for the same field settings.

The shift logic around the block raises a run enable and reads back two outputs. The first is the serial clock level, which rests at the clock-polarity value while idle. The second is a one-cycle strobe that marks every serial clock transition, so the shifter can sample on one edge and launch on the next. The block latches the divider fields and the polarity when it starts from idle. Changes to those fields while it runs therefore cannot distort an edge already in progress. Dropping the run enable parks the clock at its idle level at the next system clock and clears all counting state.

Top module: `sbr_baud_gen`

## Requirements
- R1: The 2-bit prescaler select maps code 0 to divide-by-2, code 1 to 3, code 2 to 5 and code 3 to 7.
- R2: The 4-bit scaler select maps codes 0 to 3 to divisors 2, 4, 6 and 8. Any code n from 4 to 15 divides by 2 to the power n, which gives 16 up to 32768.
- R3: With the double-rate bit clear, the total division is prescaler times scaler, and each serial clock phase, high and low, lasts exactly half of it in system clocks.
- R4: With the double-rate bit set, the total division is prescaler times scaler divided by two. The high phase lasts the rounded-up half of that and the low phase the rounded-down half.
- R5: After reset the serial clock output is 0 and the strobe is 0. While the run enable is low, the serial clock follows the polarity input one clock later and the strobe stays 0.
- R6: The block starts at the first rising clock edge that sees the run enable high while idle. The first transition then comes exactly L edges later, where L is the length of the phase whose level equals the latched polarity.
- R7: The strobe is high for exactly the one cycle in which the serial clock has just taken its new level. It is high at no other time.
- R8: At the first edge that sees the run enable low, the serial clock returns to the polarity input and the strobe clears. A later start times its first phase from zero, whatever count was reached before.
- R9: Changes to the prescaler, scaler, double-rate or polarity inputs during a run do not alter that run's phase lengths or levels. They take effect at the next start from idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_en_i | input | 1 | Run enable; high generates the serial clock |
| pre_sel_i | input | PRE_W (2) | Prescaler select (R1) |
| scl_sel_i | input | SCL_W (4) | Scaler select (R2) |
| dbl_rate_i | input | 1 | Double-rate select |
| cpol_i | input | 1 | Idle level of the serial clock |
| sck_edge_o | output | 1 | One-cycle strobe on each serial clock transition |
| sck_o | output | 1 | Serial clock level |

## Verification
The assertions check on every cycle that:
- each strobe coincides with a flip of the serial clock, and an idle block never strobes;
- a low enable stops the block at the next edge;
- the latched phase lengths are non-zero, differ by at most one and hold steady during a run;
- the phase counter never passes its limit.

Only the bench scenarios can show the following, because each needs a full expected timeline derived from the divisor tables:
- the exact divisor each code selects;
- the exact cycle of the first and of every later transition, including the uneven split under double rate;
- that fields altered mid-run leave the waveform untouched.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  // Prescaler stage: small odd or prime divisors.
  function automatic int pre_div(input int sel);
    case (sel)
      0:       return 2;
      1:       return 3;
      2:       return 5;
      default: return 7;
    endcase
  endfunction

  // Scaler stage: linear steps of two for the low codes, powers of two above.
  function automatic int scl_div(input int sel);
    if (sel < 4) return 2 * (sel + 1);
    return 1 << sel;
  endfunction

  // Total system clocks per serial clock period.
  function automatic int total_div(input int pre_sel, input int scl_sel, input bit dbl);
    int t;
    t = pre_div(pre_sel) * scl_div(scl_sel);
    if (dbl) t = t / 2;
    return t;
  endfunction

endpackage

// File: rtl/sbr_div_calc.sv
module sbr_div_calc #(
  parameter int PRE_W = 2,
  parameter int SCL_W = 4,
  parameter int LEN_W = 17
) (
  input  logic [PRE_W-1:0] pre_sel_i,
  input  logic [SCL_W-1:0] scl_sel_i,
  input  logic             dbl_rate_i,
  output logic [LEN_W-1:0] hi_len_o,
  output logic [LEN_W-1:0] lo_len_o
);
  import sbr_pkg::*;

  int tot_c;

  // Split the total period into the high and low phases; the high phase
  // absorbs the odd clock when the total is odd.
  always_comb begin
    tot_c    = total_div(int'(pre_sel_i), int'(scl_sel_i), dbl_rate_i);
    hi_len_o = LEN_W'((tot_c + 1) / 2);
    lo_len_o = LEN_W'(tot_c / 2);
  end

endmodule

// File: rtl/sbr_run_ctl.sv
module sbr_run_ctl #(
  parameter int LEN_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic [LEN_W-1:0] hi_len_i,
  input  logic [LEN_W-1:0] lo_len_i,
  output logic             active_o,
  output logic             start_o,
  output logic [LEN_W-1:0] hi_q_o,
  output logic [LEN_W-1:0] lo_q_o
);

  logic             active_q;
  logic [LEN_W-1:0] hi_q, lo_q;

  assign start_o  = run_en_i && !active_q;
  assign active_o = active_q;
  assign hi_q_o   = hi_q;
  assign lo_q_o   = lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else if (!run_en_i) begin
      active_q <= 1'b0;
    end else if (start_o) begin
      active_q <= 1'b1;
      hi_q     <= hi_len_i;
      lo_q     <= lo_len_i;
    end
  end

  AST_STOP_CLEARS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |=> !active_q); // R8
  AST_FIELDS_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && run_en_i) |=> ($stable(hi_q) && $stable(lo_q))); // R9
  AST_PHASE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (lo_q != '0)); // R3
  AST_SPLIT_UNEVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (hi_q >= lo_q && (hi_q - lo_q) <= LEN_W'(1))); // R4

endmodule

// File: rtl/sbr_edge_timer.sv
module sbr_edge_timer #(
  parameter int LEN_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             cpol_i,
  input  logic [LEN_W-1:0] hi_len_i,
  input  logic [LEN_W-1:0] lo_len_i,
  output logic             sck_o,
  output logic             edge_o
);

  logic [LEN_W-1:0] cnt_q;
  logic             sck_q, edge_q;
  logic [LEN_W-1:0] cur_len_w;
  logic             running_w, wrap_w;

  // Length of the phase currently on the line.
  assign cur_len_w = sck_q ? hi_len_i : lo_len_i;
  assign running_w = run_en_i && active_i;
  assign wrap_w    = running_w && (cnt_q == cur_len_w - LEN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sck_q  <= 1'b0;
      edge_q <= 1'b0;
    end else if (!run_en_i || start_i) begin
      cnt_q  <= '0;
      sck_q  <= cpol_i;
      edge_q <= 1'b0;
    end else if (wrap_w) begin
      cnt_q  <= '0;
      sck_q  <= !sck_q;
      edge_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + LEN_W'(1);
      edge_q <= 1'b0;
    end
  end

  assign sck_o  = sck_q;
  assign edge_o = edge_q;

  AST_EDGE_MEANS_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_q |-> (sck_q != $past(sck_q))); // R7
  AST_IDLE_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !edge_q); // R5
  AST_STOP_PARKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |=> (!edge_q && sck_q == $past(cpol_i))); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (cnt_q < cur_len_w)); // R3

endmodule

// File: rtl/sbr_baud_gen.sv
module sbr_baud_gen #(
  parameter int PRE_W = 2,
  parameter int SCL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_en_i,
  input  logic [PRE_W-1:0] pre_sel_i,
  input  logic [SCL_W-1:0] scl_sel_i,
  input  logic             dbl_rate_i,
  input  logic             cpol_i,
  output logic             sck_edge_o,
  output logic             sck_o
);

  // Largest scaler is 2^(2^SCL_W - 1); prescaler needs up to 3 bits.
  localparam int TOT_W = (1 << SCL_W) - 1 + 3;
  localparam int LEN_W = TOT_W - 1;

  logic [LEN_W-1:0] hi_len_w, lo_len_w, hi_q_w, lo_q_w;
  logic             active_w, start_w;

  sbr_div_calc #(.PRE_W(PRE_W), .SCL_W(SCL_W), .LEN_W(LEN_W)) u_calc (
    .pre_sel_i (pre_sel_i),
    .scl_sel_i (scl_sel_i),
    .dbl_rate_i(dbl_rate_i),
    .hi_len_o  (hi_len_w),
    .lo_len_o  (lo_len_w)
  );

  sbr_run_ctl #(.LEN_W(LEN_W)) u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_en_i(run_en_i),
    .hi_len_i(hi_len_w),
    .lo_len_i(lo_len_w),
    .active_o(active_w),
    .start_o (start_w),
    .hi_q_o  (hi_q_w),
    .lo_q_o  (lo_q_w)
  );

  sbr_edge_timer #(.LEN_W(LEN_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_en_i(run_en_i),
    .start_i (start_w),
    .active_i(active_w),
    .cpol_i  (cpol_i),
    .hi_len_i(hi_q_w),
    .lo_len_i(lo_q_w),
    .sck_o   (sck_o),
    .edge_o  (sck_edge_o)
  );

endmodule

// File: tb/sbr_baud_gen_bench.sv
`timescale 1ns/1ps
module sbr_baud_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic [1:0] pre = '0;
  logic [3:0] scl = '0;
  logic       dbl = 1'b0;
  logic       cpol = 1'b0;
  logic       sck_edge, sck;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = !clk;

  sbr_baud_gen u_sbr_baud_gen (
    .clk_i(clk), .rst_ni(rst_n), .run_en_i(run_en),
    .pre_sel_i(pre), .scl_sel_i(scl), .dbl_rate_i(dbl), .cpol_i(cpol),
    .sck_edge_o(sck_edge), .sck_o(sck)
  );

  function automatic int b_pre(int s);
    int tbl[4] = '{2, 3, 5, 7};
    return tbl[s];
  endfunction

  function automatic int b_scl(int s);
    int v = 1;
    if (s < 4) return 2 * s + 2;
    for (int i = 0; i < s; i++) v = v * 2;
    return v;
  endfunction

  // Period halves when the rate doubles; the high level keeps the spare clock.
  function automatic int b_phase(int p, int s, int d, int lvl);
    int period = b_pre(p) * b_scl(s);
    if (d != 0) period = period / 2;
    return (lvl != 0) ? period - period / 2 : period / 2;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Full run: ntog transitions checked every cycle, then a stop.
  task automatic run_case(int p, int s, int d, int c, int ntog, bit mutate, bit flip_stop);
    int t, nxt, tog, lvl, exp_e;
    string tag;
    @(negedge clk);
    run_en = 1'b0; pre = 2'(p); scl = 4'(s); dbl = d[0]; cpol = c[0];
    @(negedge clk); @(negedge clk);
    chk("R5 idle level", int'(sck), c);
    chk("R5 idle strobe", int'(sck_edge), 0);
    run_en = 1'b1;
    @(negedge clk);
    t = 0; lvl = c; tog = 0;
    chk("R6 level at start", int'(sck), lvl);
    chk("R6 no strobe at start", int'(sck_edge), 0);
    nxt = b_phase(p, s, d, lvl);
    while (tog < ntog) begin
      if (mutate && t == 1) begin
        pre = 2'($urandom % 4); scl = 4'($urandom % 6);
        dbl = 1'($urandom % 2); cpol = 1'($urandom % 2);
      end
      @(negedge clk);
      t++;
      exp_e = 0;
      if (t == nxt) begin
        lvl = 1 - lvl; exp_e = 1; tog++;
        nxt = t + b_phase(p, s, d, lvl);
      end
      if (mutate) tag = "R9 sck unaffected by field change";
      else if (tog == 1 && exp_e == 1) tag = "R6 first transition";
      else if (d != 0) tag = "R4 double-rate phase";
      else tag = "R3 phase length";
      chk(tag, int'(sck), lvl);
      chk("R7 strobe", int'(sck_edge), exp_e);
    end
    cpol = 1'(c ^ int'(flip_stop));
    run_en = 1'b0;
    @(negedge clk);
    chk("R8 stop level", int'(sck), int'(cpol));
    chk("R8 stop strobe", int'(sck_edge), 0);
  endtask

  // Measure the first phase; optionally run pre_run cycles and pause once before.
  task automatic measure(int p, int s, int d, int c, int pre_run, string req);
    int t;
    @(negedge clk);
    run_en = 1'b0; pre = 2'(p); scl = 4'(s); dbl = d[0]; cpol = c[0];
    @(negedge clk); @(negedge clk);
    if (pre_run > 0) begin
      run_en = 1'b1;
      repeat (pre_run) @(negedge clk);
      run_en = 1'b0;
      @(negedge clk);
    end
    run_en = 1'b1;
    @(negedge clk);
    t = 0;
    while (!sck_edge && t < 40000) begin
      @(negedge clk);
      t++;
    end
    chk(req, t, b_phase(p, s, d, c));
    run_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 reset sck", int'(sck), 0);
    chk("R5 reset strobe", int'(sck_edge), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R5 idle follows polarity", int'(sck), 1);
    cpol = 1'b0;
    @(negedge clk);
    chk("R5 idle follows polarity low", int'(sck), 0);

    for (int p = 0; p < 4; p++) measure(p, 0, 0, 0, 0, "R1 prescaler divisor");
    for (int s = 0; s < 11; s++) measure(0, s, 0, 0, 0, "R2 scaler divisor");
    measure(0, 15, 1, 0, 0, "R2 largest scaler code");
    measure(2, 3, 0, 1, 7, "R8 restart clears count");
    measure(1, 2, 1, 0, 3, "R8 restart clears count double rate");

    run_case(0, 0, 1, 0, 8, 1'b0, 1'b0);   // one clock per phase
    run_case(1, 0, 1, 0, 6, 1'b0, 1'b1);   // odd total: 2 high, 1 low
    run_case(1, 0, 1, 1, 6, 1'b0, 1'b0);
    run_case(3, 1, 1, 1, 6, 1'b0, 1'b1);   // total 14
    run_case(2, 2, 1, 0, 4, 1'b0, 1'b0);   // total 15
    run_case(3, 8, 0, 0, 4, 1'b0, 1'b0);   // total 1792
    run_case(2, 3, 0, 1, 6, 1'b1, 1'b0);   // mid-run field changes

    for (int i = 0; i < 40; i++)
      run_case($urandom % 4, $urandom % 6, $urandom % 2, $urandom % 2,
               2 + $urandom % 5, 1'($urandom % 3 == 0), 1'($urandom % 2));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R6 watchdog expired: got 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule